// File: doc/BRIEF.md
# Fused Multiply-Add Special-Case Resolver

This block sits at the front of a single-precision fused multiply-add unit that evaluates z + x·y. For each operation it receives the three operand words, a class code for each operand (worked out upstream, along with any denormal pre-normalization), two controls that negate the product and the addend, and the active rounding mode. It is purely combinational.

It first forms the adjusted product sign and the adjusted addend sign. Then it settles every case whose answer follows from operand classes alone: NaN propagation with a fixed precedence, invalid operations, infinities, and the signed-zero rules. It drives that final word together with an invalid-operation flag. When no special rule applies, it raises a compute signal instead. The arithmetic datapath downstream then takes over, using the adjusted signs this block exports.

Top module: `fma_special_resolver`

## Requirements
- R1: The exported product sign equals sign(x) XOR sign(y) XOR negProd, and the exported addend sign equals sign(z) XOR negAddend. Sign is bit 31 of each word. All decisions below use these adjusted signs.
- R2: Class codes are zero=0, normal=1, denormal=2, infinity=3, quiet NaN=4, signalling NaN=5. If any operand is a signalling NaN, the first one in the order z, x, y is returned with fraction bit 22 forced to 1, all other bits unchanged, and invalid set.
- R3: With no signalling NaN present, the first quiet NaN in the order z, x, y is returned bit-for-bit unchanged, with invalid clear.
- R4: An infinity multiplied by a zero, in either operand order, returns 0x7FC00000 with invalid set.
- R5: With an infinite product, an infinite addend whose adjusted sign differs from the product sign returns 0x7FC00000 with invalid set. Otherwise the result is infinity (exponent all ones, fraction zero) carrying the product sign, with invalid clear.
- R6: An infinite addend with a zero product or a finite nonzero product returns infinity carrying the adjusted addend sign.
- R7: A zero product with a zero addend of the same adjusted sign returns a zero of that sign. With differing signs the result is +0, or -0 when roundMode is 2'b11 (round down).
- R8: A zero product with a finite nonzero addend returns the addend word with its sign bit replaced by the adjusted addend sign.
- R9: computeEn is 1 exactly when the product is finite and nonzero and the addend is finite. In that case resultWord is 0 and invalidFlag is 0. Otherwise computeEn is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| zWord | input | 32 | Addend operand word |
| xWord | input | 32 | First multiplicand word |
| yWord | input | 32 | Second multiplicand word |
| zClass | input | 3 | Class code of z |
| xClass | input | 3 | Class code of x |
| yClass | input | 3 | Class code of y |
| negProd | input | 1 | Invert the product sign |
| negAddend | input | 1 | Invert the addend sign |
| roundMode | input | 2 | Rounding mode, 2'b11 = round down |
| resultWord | output | 32 | Final special result, 0 when computing |
| invalidFlag | output | 1 | Invalid-operation exception |
| computeEn | output | 1 | Arithmetic datapath must produce the result |
| prodSignOut | output | 1 | Adjusted product sign |
| addSignOut | output | 1 | Adjusted addend sign |

## Verification
The hardest situations to reach are those where several rules compete in one vector. One case is a signalling NaN in y together with a quiet NaN in z. Another is an infinity-by-zero product alongside an infinite addend. A third is a zero sum whose sign depends on both negate controls and the rounding mode. The stimulus reaches all of them by walking every class triple against every sign pattern, both negate bits and all four rounding modes. Each vector is compared against a behavioural model of the rule list. Every NaN operand carries a distinct payload, so a wrong precedence pick shows up as a wrong word.

// File: rtl/fma_special_pkg.sv
package fma_special_pkg;

  typedef enum logic [2:0] {
    CLS_ZERO  = 3'd0,
    CLS_NORM  = 3'd1,
    CLS_DNORM = 3'd2,
    CLS_INF   = 3'd3,
    CLS_QNAN  = 3'd4,
    CLS_SNAN  = 3'd5
  } opClass_t;

  // strobes from the decision logic to the result builder
  typedef struct packed {
    logic takeZ;
    logic takeX;
    logic takeY;
    logic quietNan;
    logic indef;
    logic infProd;
    logic infAdd;
    logic passAdd;
    logic zeroOut;
    logic zeroNeg;
    logic compute;
  } selStrobes_t;

endpackage

// File: rtl/fma_special_ctl.sv
module fma_special_ctl
  import fma_special_pkg::*;
#(
  parameter int CLS_W = 3,
  parameter int RM_W = 2,
  parameter logic [RM_W-1:0] RM_DOWN = 2'b11
) (
  input  logic [CLS_W-1:0] zClass,
  input  logic [CLS_W-1:0] xClass,
  input  logic [CLS_W-1:0] yClass,
  input  logic             prodSign,
  input  logic             addSign,
  input  logic [RM_W-1:0]  roundMode,
  output selStrobes_t      strobes
);

  logic prodInf, prodZero, addInf, addZero;

  always_comb begin
    prodInf  = (xClass == CLS_INF) || (yClass == CLS_INF);
    prodZero = (xClass == CLS_ZERO) || (yClass == CLS_ZERO);
    addInf   = (zClass == CLS_INF);
    addZero  = (zClass == CLS_ZERO);
  end

  always_comb begin
    strobes = '0;
    if (zClass == CLS_SNAN) begin
      strobes.takeZ = 1'b1; strobes.quietNan = 1'b1;
    end else if (xClass == CLS_SNAN) begin
      strobes.takeX = 1'b1; strobes.quietNan = 1'b1;
    end else if (yClass == CLS_SNAN) begin
      strobes.takeY = 1'b1; strobes.quietNan = 1'b1;
    end else if (zClass == CLS_QNAN) begin
      strobes.takeZ = 1'b1;
    end else if (xClass == CLS_QNAN) begin
      strobes.takeX = 1'b1;
    end else if (yClass == CLS_QNAN) begin
      strobes.takeY = 1'b1;
    end else if (prodInf && prodZero) begin
      strobes.indef = 1'b1;
    end else if (prodInf) begin
      if (addInf && (addSign != prodSign)) strobes.indef = 1'b1;
      else                                 strobes.infProd = 1'b1;
    end else if (addInf) begin
      strobes.infAdd = 1'b1;
    end else if (prodZero) begin
      if (addZero && (addSign != prodSign)) begin
        strobes.zeroOut = 1'b1;
        strobes.zeroNeg = (roundMode == RM_DOWN);
      end else begin
        strobes.passAdd = 1'b1;
      end
    end else begin
      strobes.compute = 1'b1;
    end
  end

  // a signalling NaN anywhere must end in a quieting pick
  always_comb begin
    if (!$isunknown({zClass, xClass, yClass}) &&
        ((zClass == CLS_SNAN) || (xClass == CLS_SNAN) || (yClass == CLS_SNAN)))
      assert_snan_quiets_R2: assert (strobes.quietNan)
        else $error("signalling NaN not quieted");
  end

endmodule

// File: rtl/fma_special_dp.sv
module fma_special_dp
  import fma_special_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EXP_W = 8
) (
  input  logic [WORD_W-1:0] zWord,
  input  logic [WORD_W-1:0] xWord,
  input  logic [WORD_W-1:0] yWord,
  input  logic              prodSign,
  input  logic              addSign,
  input  selStrobes_t       strobes,
  output logic [WORD_W-1:0] resultWord,
  output logic              invalidFlag,
  output logic              computeEn
);

  localparam int FRAC_W = WORD_W - 1 - EXP_W;
  localparam int QUIET_BIT = FRAC_W - 1;
  localparam logic [WORD_W-1:0] INDEF_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [WORD_W-1:0] nanPick;
  logic [8:0] actionVec;

  always_comb begin
    nanPick = strobes.takeZ ? zWord : (strobes.takeX ? xWord : yWord);
    if (strobes.quietNan) nanPick[QUIET_BIT] = 1'b1;
  end

  always_comb begin
    resultWord = '0;
    if (strobes.takeZ || strobes.takeX || strobes.takeY)
      resultWord = nanPick;
    else if (strobes.indef)
      resultWord = INDEF_WORD;
    else if (strobes.infProd)
      resultWord = {prodSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (strobes.infAdd)
      resultWord = {addSign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else if (strobes.passAdd)
      resultWord = {addSign, zWord[WORD_W-2:0]};
    else if (strobes.zeroOut)
      resultWord = {strobes.zeroNeg, {(WORD_W-1){1'b0}}};
    invalidFlag = strobes.quietNan | strobes.indef;
    computeEn   = strobes.compute;
  end

  always_comb begin
    actionVec = {strobes.takeZ, strobes.takeX, strobes.takeY, strobes.indef,
                 strobes.infProd, strobes.infAdd, strobes.passAdd,
                 strobes.zeroOut, strobes.compute};
    if (!$isunknown(actionVec)) begin
      assert_one_action_R9: assert ($countones(actionVec) == 1)
        else $error("action strobes not exactly one");
    end
    if (!$isunknown({computeEn, resultWord, invalidFlag}) && computeEn) begin
      assert_compute_clean_R9: assert (resultWord == '0 && !invalidFlag)
        else $error("special outputs active during compute");
    end
    if (!$isunknown({invalidFlag, resultWord}) && invalidFlag) begin
      assert_invalid_nan_R4: assert (&resultWord[WORD_W-2:QUIET_BIT])
        else $error("invalid without quiet NaN result");
    end
  end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
  import fma_special_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int EXP_W = 8,
  parameter int CLS_W = 3,
  parameter int RM_W = 2
) (
  input  logic [WORD_W-1:0] zWord,
  input  logic [WORD_W-1:0] xWord,
  input  logic [WORD_W-1:0] yWord,
  input  logic [CLS_W-1:0]  zClass,
  input  logic [CLS_W-1:0]  xClass,
  input  logic [CLS_W-1:0]  yClass,
  input  logic              negProd,
  input  logic              negAddend,
  input  logic [RM_W-1:0]   roundMode,
  output logic [WORD_W-1:0] resultWord,
  output logic              invalidFlag,
  output logic              computeEn,
  output logic              prodSignOut,
  output logic              addSignOut
);

  localparam int SIGN_BIT = WORD_W - 1;

  selStrobes_t strobes;
  logic prodSign, addSign;

  assign prodSign    = xWord[SIGN_BIT] ^ yWord[SIGN_BIT] ^ negProd;
  assign addSign     = zWord[SIGN_BIT] ^ negAddend;
  assign prodSignOut = prodSign;
  assign addSignOut  = addSign;

  fma_special_ctl #(.CLS_W(CLS_W), .RM_W(RM_W)) ctl (
    .zClass(zClass), .xClass(xClass), .yClass(yClass),
    .prodSign(prodSign), .addSign(addSign),
    .roundMode(roundMode), .strobes(strobes)
  );

  fma_special_dp #(.WORD_W(WORD_W), .EXP_W(EXP_W)) dp (
    .zWord(zWord), .xWord(xWord), .yWord(yWord),
    .prodSign(prodSign), .addSign(addSign), .strobes(strobes),
    .resultWord(resultWord), .invalidFlag(invalidFlag), .computeEn(computeEn)
  );

endmodule

// File: tb/tb_fma_special_resolver.sv
module tb_fma_special_resolver;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] zWord, xWord, yWord, resultWord;
  logic [2:0]  zClass, xClass, yClass;
  logic        negProd, negAddend, invalidFlag, computeEn, prodSignOut, addSignOut;
  logic [1:0]  roundMode;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  fma_special_resolver dut (
    .zWord(zWord), .xWord(xWord), .yWord(yWord),
    .zClass(zClass), .xClass(xClass), .yClass(yClass),
    .negProd(negProd), .negAddend(negAddend), .roundMode(roundMode),
    .resultWord(resultWord), .invalidFlag(invalidFlag), .computeEn(computeEn),
    .prodSignOut(prodSignOut), .addSignOut(addSignOut)
  );

  function automatic logic [31:0] mkWord(int cls, bit sgn, int tag);
    logic [31:0] w;
    case (cls)
      0: w = {sgn, 31'd0};
      1: w = {sgn, 8'(8'h40 + tag), 23'(23'h1234 * (tag + 1))};
      2: w = {sgn, 8'h00, 23'(23'h0101 * (tag + 1))};
      3: w = {sgn, 8'hFF, 23'd0};
      4: w = {sgn, 8'hFF, 1'b1, 22'(22'h0AB0 + tag)};
      default: w = {sgn, 8'hFF, 1'b0, 22'(22'h0150 + tag)};
    endcase
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic runVector(int zc, int xc, int yc, bit sz, bit sx, bit sy,
                           bit np, bit na, int rm);
    logic [31:0] expRes;
    bit expInv, expComp, ps, as, pInf, pZero;
    string req;
    @(negedge clk);
    zWord = mkWord(zc, sz, 0); xWord = mkWord(xc, sx, 1); yWord = mkWord(yc, sy, 2);
    zClass = 3'(zc); xClass = 3'(xc); yClass = 3'(yc);
    negProd = np; negAddend = na; roundMode = 2'(rm);
    ps = sx ^ sy ^ np; as = sz ^ na;
    pInf = (xc == 3) || (yc == 3); pZero = (xc == 0) || (yc == 0);
    expInv = 0; expComp = 0; expRes = 32'd0;
    if (zc == 5)      begin req = "R2"; expRes = zWord | 32'h0040_0000; expInv = 1; end
    else if (xc == 5) begin req = "R2"; expRes = xWord | 32'h0040_0000; expInv = 1; end
    else if (yc == 5) begin req = "R2"; expRes = yWord | 32'h0040_0000; expInv = 1; end
    else if (zc == 4) begin req = "R3"; expRes = zWord; end
    else if (xc == 4) begin req = "R3"; expRes = xWord; end
    else if (yc == 4) begin req = "R3"; expRes = yWord; end
    else if (pInf && pZero) begin req = "R4"; expRes = 32'h7FC0_0000; expInv = 1; end
    else if (pInf) begin
      req = "R5";
      if (zc == 3 && as != ps) begin expRes = 32'h7FC0_0000; expInv = 1; end
      else expRes = {ps, 8'hFF, 23'd0};
    end
    else if (zc == 3) begin req = "R6"; expRes = {as, 8'hFF, 23'd0}; end
    else if (pZero && zc == 0) begin
      req = "R7";
      if (as == ps) expRes = {as, 31'd0};
      else expRes = {(rm == 3), 31'd0};
    end
    else if (pZero) begin req = "R8"; expRes = {as, zWord[30:0]}; end
    else begin req = "R9"; expComp = 1; end
    @(posedge clk); #1;
    check(resultWord === expRes, req, resultWord, expRes);
    check(invalidFlag === expInv, req, 32'(invalidFlag), 32'(expInv));
    check(computeEn === expComp, "R9", 32'(computeEn), 32'(expComp));
    check({prodSignOut, addSignOut} === {ps, as}, "R1",
          32'({prodSignOut, addSignOut}), 32'({ps, as}));
  endtask

  initial begin
    // quiet starting point: all-zero operands give a +0 pass-through (R7)
    runVector(0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int zc = 0; zc < 6; zc++)
      for (int xc = 0; xc < 6; xc++)
        for (int yc = 0; yc < 6; yc++)
          for (int sg = 0; sg < 8; sg++)
            for (int ng = 0; ng < 4; ng++)
              for (int rm = 0; rm < 4; rm++)
                runVector(zc, xc, yc, sg[2], sg[1], sg[0], ng[1], ng[0], rm);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule